// File: doc/BRIEF.md
# SD Host Command Issue Unit

This block is the command path of an SD/MMC host controller, as software sees it through a small register window. Software fills in the argument, transfer-mode, block-size, block-count and host-control registers. It then writes a command word. If the host is free, that write launches a command. The unit passes the index, argument and response kind to a serial command engine through a one-cycle launch pulse. It sets the command-busy flag in the present-state register and then waits for the engine to hand back a response frame.

Responses come back over a valid/ready stream. The unit raises `rsp_ready` only while a response is outstanding. The engine keeps `rsp_valid` high and `rsp_frame` stable until the cycle in which both are high. A response of the short kind stores its 32 card-status bits. A long response stores its 120 payload bits with the checksum byte removed. Each finished command gives a one-cycle `cmd_done` pulse. A response kind that ends with a busy phase keeps the data-busy flag set after completion, until DAT0 is seen high. Software can therefore poll the present-state register to know when it may issue the next busy-type command.

Top module: `sd_cmd_issue`

## Requirements
- R1: After reset, every readable register returns 0 (present-state bits 23:20 excepted, which follow `dat_lines`), `rsp_ready`, `cmd_go` and `cmd_done` are low.
- R2: Register offsets are: argument 0 (32 bits), transfer mode 1 (bits 5,4,2,1,0 kept, others read 0), block size 2 (bits 14:0 kept), block count 3 (bits 15:0), command 4, present state 5, responses 6..9 (word 0 at 6), host control 10 (bits 7:0). Read-only offsets ignore writes.
- R3: A command write whose CMD-busy flag (present state bit 0) is clear is accepted. In the next cycle `cmd_go` is high for one cycle with the index from command bits 13:8, the response kind from bits 1:0 and the argument held at acceptance. Present state bit 0 then reads 1, and offset 4 reads back the accepted 14-bit word.
- R4: A command write while present-state bit 0 is set is ignored: no `cmd_go` follows and offset 4 keeps its value.
- R5: A command word with kind 01 (long) and the busy-request bit 2 set is rejected: no `cmd_go`, present state unchanged.
- R6: Kind 00 expects no response: `cmd_done` pulses in the second cycle after the accepting edge, `rsp_ready` stays low, and the response registers keep their values.
- R7: For kinds 01, 10 and 11, `rsp_ready` is high from the cycle after acceptance until the handshake. `cmd_done` pulses in the cycle after the handshake, with present-state bit 0 cleared.
- R8: Kinds 10 and 11 store `rsp_frame[39:8]` into response word 0; words 1..3 keep their values.
- R9: Kind 01 stores `rsp_frame[127:8]` across response words 0..3: word 0 gets frame bits 39:8, and word 3 gets 8 zero bits above frame bits 127:104.
- R10: Kind 11 sets present-state bit 1 on acceptance. The bit stays set after the response and clears in the cycle after DAT0 is first sampled high following the handshake. A kind-11 write while bit 1 is set is ignored.
- R11: When command bit 4 is set and the kind is 10 or 11, `cmd_idx_err` pulses together with `cmd_done` if `rsp_frame[45:40]` differs from the command index; otherwise it stays low.
- R12: Present-state bits 23:20 read the current `dat_lines` value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 4 | Write offset |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 4 | Read offset |
| reg_rdata | output | 32 | Read data (combinational) |
| cmd_go | output | 1 | One-cycle launch pulse to the command engine |
| cmd_go_index | output | 6 | Command index of the launched command |
| cmd_go_arg | output | 32 | Argument of the launched command |
| cmd_go_kind | output | 2 | Response kind of the launched command |
| rsp_valid | input | 1 | Response frame valid |
| rsp_ready | output | 1 | Response accepted when high with rsp_valid |
| rsp_frame | input | 136 | Response frame, start bit at the top of the used width |
| dat_lines | input | 4 | DAT[3:0] line levels |
| cmd_done | output | 1 | Command-complete pulse |
| cmd_idx_err | output | 1 | Index mismatch flag, valid with cmd_done |

## Verification
The assertions assume the engine keeps to the stream rule: it never withdraws `rsp_valid` before the handshake and only offers a frame for a command it has launched. The bench raises `rsp_valid` only while `rsp_ready` is high, after a random wait, and drops it right after the accepting edge. The assertions also take DAT0 to be a clean, already synchronous level. The bench changes it only between clock edges, and holds it low through each busy-type command until it chooses to release it.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  localparam int IDX_W   = 6;
  localparam int CMD_W   = 14;
  localparam int FRAME_W = 136;
  localparam int NWORDS  = 4;

  typedef enum logic [1:0] {
    RK_NONE       = 2'b00,
    RK_LONG       = 2'b01,
    RK_SHORT      = 2'b10,
    RK_SHORT_BUSY = 2'b11
  } rsp_kind_e;

  typedef struct packed {
    logic [IDX_W-1:0] idx;
    logic [1:0]       rsvd;
    logic             data_pres;
    logic             idx_chk;
    logic             crc_chk;
    logic             busy_req;
    rsp_kind_e        kind;
  } cmd_word_t;

  localparam logic [3:0] OFS_ARG    = 4'd0;
  localparam logic [3:0] OFS_XMODE  = 4'd1;
  localparam logic [3:0] OFS_BLKSZ  = 4'd2;
  localparam logic [3:0] OFS_BLKCNT = 4'd3;
  localparam logic [3:0] OFS_CMD    = 4'd4;
  localparam logic [3:0] OFS_PSTATE = 4'd5;
  localparam logic [3:0] OFS_RSP0   = 4'd6;
  localparam logic [3:0] OFS_HCTL   = 4'd10;
endpackage

// File: rtl/sdc_regs.sv
module sdc_regs
  import sdc_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [AW-1:0]         wr_addr,
  input  logic [DW-1:0]         wr_data,
  input  logic                  cmd_accept,
  input  logic [AW-1:0]         rd_addr,
  input  logic [DW-1:0]         pstate,
  input  logic [NWORDS*DW-1:0]  rsp_words,
  output logic [DW-1:0]         rd_data,
  output logic [DW-1:0]         arg_q,
  output logic                  cmd_wr
);
  localparam logic [DW-1:0] XMODE_MASK = DW'(32'h0000_0037);
  localparam logic [DW-1:0] BLKSZ_MASK = DW'(32'h0000_7FFF);
  localparam logic [DW-1:0] BLKCNT_MASK = DW'(32'h0000_FFFF);
  localparam logic [DW-1:0] HCTL_MASK  = DW'(32'h0000_00FF);

  logic [DW-1:0]    xmode_q, blksz_q, blkcnt_q, hctl_q;
  logic [CMD_W-1:0] cmd_q;

  assign cmd_wr = wr_en && (wr_addr == AW'(OFS_CMD));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arg_q    <= '0;
      xmode_q  <= '0;
      blksz_q  <= '0;
      blkcnt_q <= '0;
      hctl_q   <= '0;
      cmd_q    <= '0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          AW'(OFS_ARG):    arg_q    <= wr_data;
          AW'(OFS_XMODE):  xmode_q  <= wr_data & XMODE_MASK;
          AW'(OFS_BLKSZ):  blksz_q  <= wr_data & BLKSZ_MASK;
          AW'(OFS_BLKCNT): blkcnt_q <= wr_data & BLKCNT_MASK;
          AW'(OFS_HCTL):   hctl_q   <= wr_data & HCTL_MASK;
          default: ;
        endcase
      end
      if (cmd_accept) cmd_q <= wr_data[CMD_W-1:0];
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      AW'(OFS_ARG):    rd_data = arg_q;
      AW'(OFS_XMODE):  rd_data = xmode_q;
      AW'(OFS_BLKSZ):  rd_data = blksz_q;
      AW'(OFS_BLKCNT): rd_data = blkcnt_q;
      AW'(OFS_CMD):    rd_data = DW'(cmd_q);
      AW'(OFS_PSTATE): rd_data = pstate;
      AW'(OFS_HCTL):   rd_data = hctl_q;
      default: begin
        for (int w = 0; w < NWORDS; w++) begin
          if (rd_addr == AW'(OFS_RSP0) + AW'(w)) rd_data = rsp_words[w*DW +: DW];
        end
      end
    endcase
  end

  assert_cmd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_accept |=> $stable(cmd_q));
endmodule

// File: rtl/sdc_seq.sv
module sdc_seq
  import sdc_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [CMD_W-1:0] cmd_wdata,
  input  logic [DW-1:0]    arg_in,
  input  logic             dat0,
  input  logic             rsp_valid,
  input  logic [IDX_W-1:0] rsp_idx,
  output logic             cmd_accept,
  output logic             cmd_go,
  output logic [IDX_W-1:0] go_index,
  output logic [DW-1:0]    go_arg,
  output logic [1:0]       go_kind,
  output logic             rsp_ready,
  output logic             rsp_take,
  output logic             take_long,
  output logic             cmd_done,
  output logic             idx_err,
  output logic             cmd_inh,
  output logic             dat_inh
);
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_FIN} st_e;

  st_e              st_q;
  cmd_word_t        cw, cur_q;
  logic             long_busy_bad, dat_block, busy_wait_q;

  always_comb begin
    cw            = cmd_word_t'(cmd_wdata);
    long_busy_bad = (cw.kind == RK_LONG) && cw.busy_req;
    dat_block     = (cw.kind == RK_SHORT_BUSY) && dat_inh;
    cmd_accept    = cmd_wr && !cmd_inh && !long_busy_bad && !dat_block;
  end

  assign rsp_ready = (st_q == ST_WAIT);
  assign rsp_take  = rsp_ready && rsp_valid;
  assign take_long = (cur_q.kind == RK_LONG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      cur_q       <= '0;
      cmd_inh     <= 1'b0;
      dat_inh     <= 1'b0;
      busy_wait_q <= 1'b0;
      cmd_go      <= 1'b0;
      go_index    <= '0;
      go_arg      <= '0;
      go_kind     <= '0;
      cmd_done    <= 1'b0;
      idx_err     <= 1'b0;
    end else begin
      cmd_go   <= cmd_accept;
      cmd_done <= 1'b0;
      idx_err  <= 1'b0;
      if (busy_wait_q && dat0) begin
        busy_wait_q <= 1'b0;
        dat_inh     <= 1'b0;
      end
      if (cmd_accept) begin
        cur_q    <= cw;
        go_index <= cw.idx;
        go_arg   <= arg_in;
        go_kind  <= cw.kind;
        cmd_inh  <= 1'b1;
        st_q     <= (cw.kind == RK_NONE) ? ST_FIN : ST_WAIT;
        if (cw.kind == RK_SHORT_BUSY) dat_inh <= 1'b1;
      end else begin
        case (st_q)
          ST_FIN: begin
            cmd_done <= 1'b1;
            cmd_inh  <= 1'b0;
            st_q     <= ST_IDLE;
          end
          ST_WAIT: if (rsp_valid) begin
            cmd_done <= 1'b1;
            cmd_inh  <= 1'b0;
            idx_err  <= cur_q.idx_chk && (cur_q.kind != RK_LONG) && (rsp_idx != cur_q.idx);
            if (cur_q.kind == RK_SHORT_BUSY) busy_wait_q <= 1'b1;
            st_q     <= ST_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

  assert_no_go_when_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_inh) |=> !cmd_go);
  assert_reject_long_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cw.kind == RK_LONG && cw.busy_req) |=> !cmd_go);
  assert_go_sets_inhibit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go |-> cmd_inh);
  assert_ready_while_inhibit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> cmd_inh);
  assert_done_frees_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |-> !cmd_inh);
  assert_valid_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid);
  assert_dat_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dat_inh) |-> $past(dat0));
  assert_err_with_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    idx_err |-> cmd_done);
endmodule

// File: rtl/sdc_rsp_cap.sv
module sdc_rsp_cap
  import sdc_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 take,
  input  logic                 take_long,
  input  logic [FRAME_W-1:0]   frame,
  output logic [NWORDS*DW-1:0] words
);
  localparam int STRIP  = 8;
  localparam int PAY_W  = NWORDS * DW - STRIP;

  logic [NWORDS*DW-1:0] long_img;
  assign long_img = {{STRIP{1'b0}}, frame[PAY_W+STRIP-1:STRIP]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      words <= '0;
    end else if (take) begin
      if (take_long) words <= long_img;
      else           words[DW-1:0] <= frame[DW+STRIP-1:STRIP];
    end
  end

  assert_upper_kept_short_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !take_long) |=> $stable(words[NWORDS*DW-1:DW]));
  assert_idle_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(words));
endmodule

// File: rtl/sd_cmd_issue.sv
module sd_cmd_issue
  import sdc_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [AW-1:0]      reg_waddr,
  input  logic [DW-1:0]      reg_wdata,
  input  logic [AW-1:0]      reg_raddr,
  output logic [DW-1:0]      reg_rdata,
  output logic               cmd_go,
  output logic [IDX_W-1:0]   cmd_go_index,
  output logic [DW-1:0]      cmd_go_arg,
  output logic [1:0]         cmd_go_kind,
  input  logic               rsp_valid,
  output logic               rsp_ready,
  input  logic [FRAME_W-1:0] rsp_frame,
  input  logic [3:0]         dat_lines,
  output logic               cmd_done,
  output logic               cmd_idx_err
);
  localparam int IDX_LO = 40;

  logic                 cmd_wr, cmd_accept, rsp_take, take_long, cmd_inh, dat_inh;
  logic [DW-1:0]        arg_q, pstate;
  logic [NWORDS*DW-1:0] rsp_words;

  assign pstate = DW'({8'h00, dat_lines, 18'h0_0000, dat_inh, cmd_inh});

  sdc_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_we), .wr_addr(reg_waddr), .wr_data(reg_wdata),
    .cmd_accept(cmd_accept), .rd_addr(reg_raddr),
    .pstate(pstate), .rsp_words(rsp_words), .rd_data(reg_rdata),
    .arg_q(arg_q), .cmd_wr(cmd_wr)
  );

  sdc_seq #(.DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_wr(cmd_wr), .cmd_wdata(reg_wdata[CMD_W-1:0]), .arg_in(arg_q),
    .dat0(dat_lines[0]), .rsp_valid(rsp_valid),
    .rsp_idx(rsp_frame[IDX_LO +: IDX_W]),
    .cmd_accept(cmd_accept), .cmd_go(cmd_go), .go_index(cmd_go_index),
    .go_arg(cmd_go_arg), .go_kind(cmd_go_kind),
    .rsp_ready(rsp_ready), .rsp_take(rsp_take), .take_long(take_long),
    .cmd_done(cmd_done), .idx_err(cmd_idx_err),
    .cmd_inh(cmd_inh), .dat_inh(dat_inh)
  );

  sdc_rsp_cap #(.DW(DW)) u_cap (
    .clk(clk), .rst_n(rst_n),
    .take(rsp_take), .take_long(take_long),
    .frame(rsp_frame), .words(rsp_words)
  );
endmodule

// File: tb/sd_cmd_issue_tb.sv
module sd_cmd_issue_tb;
  logic         clk = 0, rst_n = 0;
  logic         reg_we = 0;
  logic [3:0]   reg_waddr = 0, reg_raddr = 0;
  logic [31:0]  reg_wdata = 0, reg_rdata;
  logic         cmd_go, rsp_valid = 0, rsp_ready, cmd_done, cmd_idx_err;
  logic [5:0]   cmd_go_index;
  logic [31:0]  cmd_go_arg;
  logic [1:0]   cmd_go_kind;
  logic [135:0] rsp_frame = '0;
  logic [3:0]   dat_lines = 4'h0;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [31:0] mdl_rsp [4];
  logic [31:0] mdl_arg = 0;
  logic [13:0] mdl_cmd = 0;

  always #2.5 clk = ~clk;

  sd_cmd_issue u_dut (.*);

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_waddr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_raddr = a; #0.5; d = reg_rdata;
  endtask

  function automatic logic [31:0] exp_word(input logic [135:0] fr, input int w);
    logic [127:0] img = {8'h00, fr[127:8]};
    return img[w*32 +: 32];
  endfunction

  task automatic check_rsp(input string req);
    logic [31:0] d;
    for (int w = 0; w < 4; w++) begin
      rd(4'(6 + w), d);
      chk(d == mdl_rsp[w], req, d, mdl_rsp[w]);
    end
  endtask

  // full command with response; dly cycles before valid
  task automatic run_cmd(input logic [13:0] w, input logic [135:0] fr, input int dly);
    logic [1:0] k = w[1:0];
    logic [31:0] d;
    bit exp_err;
    if (k == 2'b11) dat_lines[0] = 0;
    wr(4'd4, w);
    mdl_cmd = w;
    chk(cmd_go == 1, "R3 go", cmd_go, 1);
    chk(cmd_go_index == w[13:8] && cmd_go_kind == k && cmd_go_arg == mdl_arg, "R3 launch fields",
        {cmd_go_index, cmd_go_kind, cmd_go_arg}, {w[13:8], k, mdl_arg});
    rd(4'd5, d);
    chk(d[0] == 1, "R3 cmd inhibit set", d, 1);
    rd(4'd4, d);
    chk(d == 32'(w), "R3 cmd readback", d, w);
    if (k == 2'b00) begin
      chk(rsp_ready == 0 && cmd_done == 0, "R6 no ready", {rsp_ready, cmd_done}, 0);
      @(negedge clk);
      chk(cmd_done == 1 && rsp_ready == 0, "R6 done", {cmd_done, rsp_ready}, 2'b10);
      check_rsp("R6 rsp kept");
    end else begin
      for (int i = 0; i < dly; i++) begin
        chk(rsp_ready == 1 && cmd_done == 0, "R7 waiting", {rsp_ready, cmd_done}, 2'b10);
        @(negedge clk);
      end
      chk(rsp_ready == 1, "R7 ready", rsp_ready, 1);
      rsp_valid = 1; rsp_frame = fr;
      @(negedge clk);
      rsp_valid = 0;
      exp_err = w[4] && (k != 2'b01) && (fr[45:40] != w[13:8]);
      chk(cmd_done == 1 && rsp_ready == 0, "R7 done", {cmd_done, rsp_ready}, 2'b10);
      chk(cmd_idx_err == exp_err, "R11 index check", cmd_idx_err, exp_err);
      rd(4'd5, d);
      chk(d[0] == 0, "R7 cmd inhibit clear", d, 0);
      if (k == 2'b01) for (int i = 0; i < 4; i++) mdl_rsp[i] = exp_word(fr, i);
      else mdl_rsp[0] = fr[39:8];
      check_rsp(k == 2'b01 ? "R9 long capture" : "R8 short capture");
      if (k == 2'b11) begin
        @(negedge clk); @(negedge clk);
        rd(4'd5, d);
        chk(d[1] == 1, "R10 dat inhibit held", d, 1);
        dat_lines[0] = 1;
        @(negedge clk);
        rd(4'd5, d);
        chk(d[1] == 0, "R10 dat inhibit released", d, 0);
      end
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, v;
    logic [135:0] fr;
    logic [13:0] w;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4; i++) mdl_rsp[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 11; a++) begin
      rd(4'(a), d);
      chk(d == 0, "R1 reset regs", d, 0);
    end
    chk(rsp_ready == 0 && cmd_go == 0 && cmd_done == 0, "R1 outputs idle",
        {rsp_ready, cmd_go, cmd_done}, 0);

    // R2 register masks, random values
    for (int n = 0; n < 4; n++) begin
      v = $urandom; wr(4'd1, v); rd(4'd1, d); chk(d == (v & 32'h37), "R2 xmode", d, v & 32'h37);
      v = $urandom; wr(4'd2, v); rd(4'd2, d); chk(d == (v & 32'h7FFF), "R2 blksz", d, v & 32'h7FFF);
      v = $urandom; wr(4'd3, v); rd(4'd3, d); chk(d == (v & 32'hFFFF), "R2 blkcnt", d, v & 32'hFFFF);
      v = $urandom; wr(4'd10, v); rd(4'd10, d); chk(d == (v & 32'hFF), "R2 hctl", d, v & 32'hFF);
      v = $urandom; wr(4'd0, v); mdl_arg = v; rd(4'd0, d); chk(d == v, "R2 arg", d, v);
    end
    wr(4'd5, 32'hFFFF_FFFF); rd(4'd5, d);
    chk(d[1:0] == 0, "R2 pstate read-only", d, 0);
    wr(4'd6, 32'hFFFF_FFFF); rd(4'd6, d);
    chk(d == 0, "R2 rsp read-only", d, 0);

    // R12 line mirror
    for (int n = 0; n < 4; n++) begin
      dat_lines = 4'($urandom);
      rd(4'd5, d);
      chk(d[23:20] == dat_lines, "R12 dat lines", d[23:20], dat_lines);
    end
    dat_lines = 4'hF;

    // directed: no-response, short, long, busy
    run_cmd({6'd0, 8'h00}, '0, 0);
    fr = {$urandom, $urandom, $urandom, $urandom, 8'($urandom)};
    fr[45:40] = 6'd17;
    run_cmd({6'd17, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 2'b10}, fr, 2);
    fr = {$urandom, $urandom, $urandom, $urandom, 8'($urandom)};
    run_cmd({6'd2, 8'h09}, fr, 1);
    fr[45:40] = 6'd7;
    run_cmd({6'd7, 8'h1B}, fr, 0);

    // R11 mismatch
    fr[45:40] = 6'd9;
    run_cmd({6'd8, 8'h12}, fr, 0);

    // R5 long + busy request rejected
    wr(4'd4, 32'(14'h0D05));
    chk(cmd_go == 0, "R5 rejected", cmd_go, 0);
    rd(4'd5, d);
    chk(d[1:0] == 0, "R5 no state", d, 0);
    rd(4'd4, d);
    chk(d == 32'(mdl_cmd), "R5 cmd kept", d, mdl_cmd);

    // R4 write while CMD inhibit set
    wr(4'd4, 32'(14'h0502));
    chk(cmd_go == 1, "R3 go before R4", cmd_go, 1);
    mdl_cmd = 14'h0502;
    wr(4'd4, 32'(14'h0600));
    chk(cmd_go == 0, "R4 ignored go", cmd_go, 0);
    rd(4'd4, d);
    chk(d == 32'h0502, "R4 cmd kept", d, 32'h0502);
    chk(rsp_ready == 1, "R7 still waiting", rsp_ready, 1);
    fr = {$urandom, $urandom, $urandom, $urandom, 8'($urandom)};
    rsp_valid = 1; rsp_frame = fr;
    @(negedge clk); rsp_valid = 0;
    chk(cmd_done == 1, "R7 done after R4", cmd_done, 1);
    mdl_rsp[0] = fr[39:8];
    check_rsp("R8 capture after R4");

    // R10 busy type blocked while DAT inhibit set, others allowed
    dat_lines[0] = 0;
    wr(4'd4, 32'(14'h0D03));
    chk(cmd_go == 1, "R3 busy go", cmd_go, 1);
    rsp_valid = 1; fr = {$urandom, $urandom, $urandom, $urandom, 8'($urandom)}; rsp_frame = fr;
    @(negedge clk); rsp_valid = 0;
    mdl_rsp[0] = fr[39:8];
    wr(4'd4, 32'(14'h0E03));
    chk(cmd_go == 0, "R10 busy blocked", cmd_go, 0);
    rd(4'd5, d);
    chk(d[1:0] == 2'b10, "R10 dat inhibit only", d[1:0], 2'b10);
    run_cmd({6'd4, 8'h00}, '0, 0);
    rd(4'd5, d);
    chk(d[1] == 1, "R10 still held", d, 1);
    dat_lines[0] = 1;
    @(negedge clk);
    rd(4'd5, d);
    chk(d[1] == 0, "R10 release", d, 0);

    // random mix
    for (int n = 0; n < 40; n++) begin
      v = $urandom; wr(4'd0, v); mdl_arg = v;
      w = 14'($urandom);
      w[2] = 0;
      fr = {$urandom, $urandom, $urandom, $urandom, 8'($urandom)};
      if ($urandom % 2) fr[45:40] = w[13:8];
      run_cmd(w, fr, int'($urandom % 4));
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule